// File: doc/BRIEF.md
# Bit-Serial Interrupt and Pin Interface

This peripheral hangs on a bit-serial I/O bus, where each bus cycle transfers one bit to or from an address. It takes up 32 consecutive bit slots. The bus carries the address as a word address, bits 15 to 1 of a byte address, so the slots sit at even byte addresses 0x0000 to 0x003E when the tag parameter is zero. A multi-bit transfer on this bus is a run of single-bit cycles at rising slots, so it needs no separate path.

The lower half of the slot map holds a control bit at slot 0 and fifteen active-low interrupt lines at slots 1 to 15. Writing a slot in that range sets the enable of that line. Reading it returns the live level of the line. A combinational encoder raises the interrupt request while any enabled line is low and reports the lowest such line number on a 4-bit code. The upper half, slots 16 to 31, is sixteen latched output pins that can be read back.

Top module: `bitio_intc`

## Requirements
- R1: While reset is held, and after it is released, every line enable, every pin latch and the control bit are 0. The outputs then read pinOut = 0, intReq = 0 and intCode = 0.
- R2: A bus cycle acts on the block only when sel is 1 and bitAddr[14:5] equals the tag parameter (default 0). Any other cycle changes no state and reads back rdBit = 0. Slot 32 (byte address 0x0040) is outside the block.
- R3: A write to slot 0 stores wrBit in the control bit, and a read of slot 0 returns it.
- R4: A write to slot n, with n from 1 to 15, sets the enable of line n to wrBit. It leaves the pin latches unchanged.
- R5: A read of slot n, with n from 1 to 15, returns the present level of intN[n], whether line n is enabled or not.
- R6: intReq is 1 exactly when some line n has its enable at 1 and intN[n] = 0. intCode then equals the smallest such n. intCode is 0 whenever intReq is 0.
- R7: A write to slot 16+k, with k from 0 to 15, loads wrBit into pin latch k, which drives pinOut[k]. The latch holds its value until its own slot is written again, and a read of slot 16+k returns it.
- R8: Slot 21 (byte address 0x002A) is pin 5, so writing it changes pinOut[5] alone.
- R9: The request is level-sensitive. It drops in the same cycle that the last enabled low line goes high or has its enable cleared, and no write is needed to clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Bit cycle strobe |
| wrEn | input | 1 | 1 for a write cycle, 0 for a read cycle |
| bitAddr | input | 15 | Bit address (byte address bits 15:1) |
| wrBit | input | 1 | Bit to write |
| rdBit | output | 1 | Bit read from the addressed slot |
| intN | input | 15 | Interrupt lines 1 to 15, active low (index = line number) |
| pinOut | output | 16 | Latched programmable pins |
| intReq | output | 1 | Interrupt request |
| intCode | output | 4 | Lowest enabled active line number |

## Verification
The encoder is driven with combinations of enable masks and line levels that each separate one failure. These are all lines low with nothing enabled, all lines enabled with all lines high, a single enabled line at the top slot, every line active at once, and low lines whose only lower neighbour is masked off. Together they show whether the mask gates each line, and whether the lowest line wins rather than the highest. Directed cases then check the following:
- pin write and readback with patterns that hold a 1 and a 0 in neighbouring pins;
- that slot 21 lands on pin 5;
- that writes to the mask half and reads there leave the pins untouched, while a read of a disabled line still shows its level;
- that writes outside the window or without the strobe change nothing;
- that the request clears when a line goes back high or when its enable is cleared.

// File: rtl/bitio_pkg.sv
package bitio_pkg;
  localparam int SLOT_COUNT = 32;
  localparam int SLOT_W = $clog2(SLOT_COUNT);
  localparam int HALF = SLOT_COUNT / 2;
  localparam int LINE_COUNT = HALF - 1;
  localparam int CODE_W = $clog2(HALF);

  typedef struct packed {
    logic              rdHit;
    logic              wrCtrl;
    logic              wrMask;
    logic              wrPin;
    logic [SLOT_W-1:0] slot;
  } strobe_t;
endpackage

// File: rtl/bitio_ctrl.sv
module bitio_ctrl
  import bitio_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BASE_TAG = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] bitAddr,
  output strobe_t           strb
);
  localparam int TAG_W = ADDR_W - SLOT_W;
  localparam logic [TAG_W-1:0] TAG = TAG_W'(BASE_TAG);

  logic              hit;
  logic [SLOT_W-1:0] slot;
  logic              upperHalf;

  assign slot      = bitAddr[SLOT_W-1:0];
  assign hit       = sel && (bitAddr[ADDR_W-1:SLOT_W] == TAG);
  assign upperHalf = slot[SLOT_W-1];

  always_comb begin
    strb        = '0;
    strb.slot   = slot;
    strb.rdHit  = hit && !wrEn;
    strb.wrCtrl = hit && wrEn && !upperHalf && (slot == '0);
    strb.wrMask = hit && wrEn && !upperHalf && (slot != '0);
    strb.wrPin  = hit && wrEn && upperHalf;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdHit, strb.wrCtrl, strb.wrMask, strb.wrPin})); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !sel |-> !(strb.rdHit || strb.wrCtrl || strb.wrMask || strb.wrPin)); // R2
endmodule

// File: rtl/bitio_datapath.sv
module bitio_datapath
  import bitio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic                  wrBit,
  input  logic [LINE_COUNT:1]   intN,
  output logic                  rdBit,
  output logic [HALF-1:0]       pinOut,
  output logic                  intReq,
  output logic [CODE_W-1:0]     intCode
);
  logic [LINE_COUNT:1] maskQ;
  logic [HALF-1:0]     pinQ;
  logic                ctrlQ;
  logic [CODE_W-1:0]   lowSlot;
  logic [HALF-1:0]     levelView;
  logic [HALF-1:0]     maskView;
  logic [LINE_COUNT:1] pending;

  assign lowSlot   = strb.slot[CODE_W-1:0];
  assign levelView = {intN, ctrlQ};
  assign maskView  = {maskQ, 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= 1'b0;
    else if (strb.wrCtrl) ctrlQ <= wrBit;
  end

  for (genvar n = 1; n <= LINE_COUNT; n++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) maskQ[n] <= 1'b0;
      else if (strb.wrMask && lowSlot == CODE_W'(n)) maskQ[n] <= wrBit;
    end
  end

  for (genvar k = 0; k < HALF; k++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pinQ[k] <= 1'b0;
      else if (strb.wrPin && lowSlot == CODE_W'(k)) pinQ[k] <= wrBit;
    end
  end

  assign pending = maskQ & ~intN;

  always_comb begin
    intCode = '0;
    for (int n = LINE_COUNT; n >= 1; n--) begin
      if (pending[n]) intCode = CODE_W'(n);
    end
  end

  assign intReq = |pending;
  assign pinOut = pinQ;

  always_comb begin
    rdBit = 1'b0;
    if (strb.rdHit) begin
      if (strb.slot[SLOT_W-1]) rdBit = pinQ[lowSlot];
      else rdBit = levelView[lowSlot];
    end
  end

  AST_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (maskView[intCode] && !levelView[intCode] && intCode != '0)); // R6

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    !intReq |-> (intCode == '0)); // R6

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !intReq); // R9

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPin |=> $stable(pinOut)); // R7

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrMask |=> $stable(maskQ)); // R4

  AST_PIN5_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrPin && strb.slot == SLOT_W'(21)) |=> (pinOut[5] == $past(wrBit))); // R8
endmodule

// File: rtl/bitio_intc.sv
module bitio_intc
  import bitio_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BASE_TAG = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sel,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   bitAddr,
  input  logic                wrBit,
  output logic                rdBit,
  input  logic [LINE_COUNT:1] intN,
  output logic [HALF-1:0]     pinOut,
  output logic                intReq,
  output logic [CODE_W-1:0]   intCode
);
  strobe_t strb;

  bitio_ctrl #(.ADDR_W(ADDR_W), .BASE_TAG(BASE_TAG)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sel     (sel),
    .wrEn    (wrEn),
    .bitAddr (bitAddr),
    .strb    (strb)
  );

  bitio_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrBit   (wrBit),
    .intN    (intN),
    .rdBit   (rdBit),
    .pinOut  (pinOut),
    .intReq  (intReq),
    .intCode (intCode)
  );
endmodule

// File: tb/bitio_intc_test.sv
module bitio_intc_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0;
  logic        wrEn = 1'b0;
  logic [14:0] bitAddr = '0;
  logic        wrBit = 1'b0;
  logic        rdBit;
  logic [15:1] intN = '1;
  logic [15:0] pinOut;
  logic        intReq;
  logic [3:0]  intCode;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bitio_intc uut (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .bitAddr(bitAddr),
    .wrBit(wrBit), .rdBit(rdBit), .intN(intN), .pinOut(pinOut),
    .intReq(intReq), .intCode(intCode)
  );

  // mask (bit 0 unused), line levels (bit 0 unused), expected req, expected code
  typedef struct packed {
    logic [15:0] mask;
    logic [15:0] lines;
    logic        req;
    logic [3:0]  code;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'h0000, 16'h0000, 1'b0, 4'd0},
    '{16'hFFFE, 16'hFFFE, 1'b0, 4'd0},
    '{16'hFFFE, 16'hFF7E, 1'b1, 4'd7},
    '{16'hFFFE, 16'h0000, 1'b1, 4'd1},
    '{16'h8000, 16'h7FFE, 1'b1, 4'd15},
    '{16'h0010, 16'hFFE6, 1'b1, 4'd4},
    '{16'h0028, 16'hFDDE, 1'b1, 4'd5},
    '{16'h0028, 16'hFFEA, 1'b0, 4'd0}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeSlot(int slot, logic val);
    @(negedge clk);
    sel = 1'b1; wrEn = 1'b1; bitAddr = 15'(slot); wrBit = val;
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b0;
  endtask

  task automatic readSlot(int slot, output logic val);
    @(negedge clk);
    sel = 1'b1; wrEn = 1'b0; bitAddr = 15'(slot);
    #1 val = rdBit;
    sel = 1'b0;
  endtask

  task automatic loadMask(logic [15:0] m);
    for (int n = 1; n < 16; n++) writeSlot(n, m[n]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic b;
    repeat (3) @(negedge clk);
    check("R1 pins in reset", pinOut, 16'h0000);
    intN = '0;
    #1 check("R1 req in reset", {15'b0, intReq}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 code after reset", {12'b0, intCode}, 16'h0);
    check("R1 req after reset", {15'b0, intReq}, 16'h0);
    readSlot(0, b);
    check("R1 ctrl after reset", {15'b0, b}, 16'h0);
    intN = '1;

    // table of encoder patterns
    for (int i = 0; i < 8; i++) begin
      loadMask(VECS[i].mask);
      intN = VECS[i].lines[15:1];
      @(negedge clk);
      check($sformatf("R6 req vec%0d", i), {15'b0, intReq}, {15'b0, VECS[i].req});
      check($sformatf("R6 code vec%0d", i), {12'b0, intCode}, {12'b0, VECS[i].code});
    end
    check("R4 mask writes leave pins", pinOut, 16'h0000);

    // R9: deassert when line goes high, then when enable cleared
    loadMask(16'h0004);
    intN = 15'h7FFF & ~15'h0002;
    #1 check("R9 asserted", {15'b0, intReq}, 16'h1);
    intN = '1;
    #1 check("R9 drop on line high", {15'b0, intReq}, 16'h0);
    intN = '0;
    #1 check("R9 reasserted", {12'b0, intCode}, 16'h2);
    writeSlot(2, 1'b0);
    check("R9 drop on enable clear", {15'b0, intReq}, 16'h0);

    // R5: read level of a disabled line
    intN = 15'h7FFF & ~15'h0040;  // line 7 low
    readSlot(7, b);
    check("R5 disabled line low", {15'b0, b}, 16'h0);
    readSlot(8, b);
    check("R5 disabled line high", {15'b0, b}, 16'h1);
    intN = '1;

    // R3 control bit
    writeSlot(0, 1'b1);
    readSlot(0, b);
    check("R3 ctrl set", {15'b0, b}, 16'h1);
    check("R3 ctrl no req", {15'b0, intReq}, 16'h0);

    // R7 pins
    for (int k = 0; k < 16; k++) writeSlot(16 + k, k[0] ^ k[2]);
    check("R7 pin pattern", pinOut, 16'h5A5A);
    readSlot(17, b);
    check("R7 read pin1", {15'b0, b}, 16'h1);
    readSlot(16, b);
    check("R7 read pin0", {15'b0, b}, 16'h0);
    writeSlot(16 + 3, 1'b1);
    check("R7 single pin", pinOut, 16'h5A5A | 16'h0008);

    // R8 slot 21 is pin 5
    writeSlot(21, 1'b1);
    check("R8 pin5 set", pinOut, 16'h5A7A);
    writeSlot(21, 1'b0);
    check("R8 pin5 clear", pinOut, 16'h5A5A);

    // R2 out-of-window and unselected cycles
    writeSlot(32, 1'b1);
    writeSlot(32 + 16, 1'b1);
    writeSlot(15'h0400 | 15'd20, 1'b1);
    check("R2 outside window pins", pinOut, 16'h5A5A);
    intN = '0;
    writeSlot(32 + 5, 1'b1);
    #1 check("R2 outside window mask", {15'b0, intReq}, 16'h0);
    @(negedge clk);
    wrEn = 1'b1; bitAddr = 15'd20; wrBit = 1'b1; sel = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
    check("R2 no sel no write", pinOut, 16'h5A5A);
    readSlot(32 + 17, b);
    check("R2 outside read zero", {15'b0, b}, 16'h0);
    intN = '1;

    // R1 reset again clears state
    @(negedge clk);
    rstN = 1'b0;
    #1 check("R1 reset clears pins", pinOut, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    intN = '0;
    #1 check("R1 reset clears masks", {15'b0, intReq}, 16'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule